// File: doc/BRIEF.md
# Parallel Prefix Scan Unit

The unit takes a vector of `N` unsigned integer elements and produces all `N` inclusive running sums in one step. Output `i` is the sum of input elements `0` through `i`, so output `0` repeats element `0` and output `N-1` is the total of the whole vector. The sums are not formed by one accumulator or by a chain of adders. A tree of `log2(N)` adder levels builds them by regrouping additions, which is valid because addition is associative. At level `k`, each position `j >= 2^k` adds the partial result held at position `j - 2^k`.

Each running sum is `log2(N)` bits wider than an element, so no result can overflow. The parameter `REGISTER_OUT` sets the output timing. With `REGISTER_OUT=1` the sums pass through one clocked stage, and a synchronous active-high reset clears that stage. With `REGISTER_OUT=0` the unit is purely combinational.

Element `k` occupies bits `[k*W +: W]` of `elems_i`. Sum `k` occupies bits `[k*SW +: SW]` of `sums_o`, where `SW = W + log2(N)`.

Top module: `prefix_sum_scan`

## Requirements
- R1: Sum 0 equals element 0, zero-extended.
- R2: For every index i, sum i equals the exact serial total of elements 0 through i, for any input vector.
- R3: Sum N-1 equals the total of all N elements.
- R4: With N=8 and elements 1,2,3,4,5,6,7,8 (element 0 first), the sums are 1,3,6,10,15,21,28,36.
- R5: When every element is 2^W-1, sum i equals (i+1)*(2^W-1) exactly, with no wrap-around.
- R6: The sums never decrease as the index grows.
- R7: With REGISTER_OUT=1, the sums seen after a rising clock edge are those of the inputs present at that edge, so the latency is one cycle.
- R8: With REGISTER_OUT=1, a rising edge with rst high clears every sum to 0, whatever the inputs are.
- R9: With REGISTER_OUT=0, the sums follow the inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| elems_i | input | N*W | Packed input elements, element 0 in the low bits |
| sums_o | output | N*(W+log2 N) | Packed inclusive running sums, sum 0 in the low bits |

## Verification
The unit is tried with the following input patterns:

- **Ascending ramp.** Confirms the known sum sequence.
- **All zeros.** Shows that no constant leaks into a sum.
- **All maximum.** Exposes any loss of carry width in the widest sums.
- **One nonzero element, swept over every position.** Reveals a wrong stride at any tree level. Such a fault would put the value in the wrong outputs or leave it out of some.
- **Alternating and pseudo-random vectors.** Compared against a serial reference, to catch mixed-carry errors.

Registered and combinational instances run side by side, which separates latency and reset faults from arithmetic faults.

// File: rtl/prefix_sum_scan.sv
module prefix_sum_scan #(
  parameter int N            = 8,
  parameter int W            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N*W-1:0]                  elems_i,
  output logic [N*(W+$clog2(N))-1:0]      sums_o
);
  localparam int LG = $clog2(N);
  localparam int SW = W + LG;

  logic [SW-1:0] lvl [LG+1][N];
  logic [N*SW-1:0] tree_sums;

  for (genvar j = 0; j < N; j++) begin : g_load
    assign lvl[0][j] = SW'(elems_i[j*W +: W]);
    assign tree_sums[j*SW +: SW] = lvl[LG][j];
  end

  for (genvar k = 0; k < LG; k++) begin : g_level
    for (genvar j = 0; j < N; j++) begin : g_pos
      if (j >= (1 << k)) begin : g_add
        assign lvl[k+1][j] = lvl[k][j] + lvl[k][j-(1<<k)];
      end else begin : g_pass
        assign lvl[k+1][j] = lvl[k][j];
      end
    end
  end

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) sums_o <= '0;
      else     sums_o <= tree_sums;
    end
  end else begin : g_comb
    assign sums_o = tree_sums;
  end
endmodule

// File: rtl/prefix_sum_scan_chk.sv
module prefix_sum_scan_chk #(
  parameter int N            = 8,
  parameter int W            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N*W-1:0]             elems_i,
  input logic [N*(W+$clog2(N))-1:0] sums_o
);
  localparam int SW = W + $clog2(N);

  logic [N*SW-1:0] ref_v;
  logic            armed = 1'b0;

  always_comb begin
    logic [SW-1:0] acc;
    acc   = '0;
    ref_v = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + SW'(elems_i[i*W +: W]);
      ref_v[i*SW +: SW] = acc;
    end
  end

  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  if (REGISTER_OUT) begin : g_reg_chk
    a_r2_serial_match: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(rst) |-> sums_o == $past(ref_v));
    a_r1_first_elem: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(rst) |-> sums_o[SW-1:0] == SW'($past(elems_i[W-1:0])));
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!armed)
      rst |=> sums_o == '0);
  end else begin : g_comb_chk
    a_r9_serial_match: assert property (@(posedge clk) disable iff (rst)
      sums_o == ref_v);
    a_r1_first_elem: assert property (@(posedge clk) disable iff (rst)
      sums_o[SW-1:0] == SW'(elems_i[W-1:0]));
  end

  for (genvar i = 1; i < N; i++) begin : g_mono
    a_r6_nondecreasing: assert property (@(posedge clk) disable iff (rst || !armed)
      sums_o[i*SW +: SW] >= sums_o[(i-1)*SW +: SW]);
  end
endmodule

bind prefix_sum_scan prefix_sum_scan_chk #(.N(N), .W(W), .REGISTER_OUT(REGISTER_OUT)) chk_i (
  .clk(clk), .rst(rst), .elems_i(elems_i), .sums_o(sums_o)
);

// File: tb/prefix_sum_scan_tb_top.sv
module prefix_sum_scan_tb_top;
  localparam int CLK_P = 10;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int SW = W + $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*W-1:0]  elems = '0;
  logic [N*SW-1:0] sums_r, sums_c;
  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  prefix_sum_scan #(.N(N), .W(W), .REGISTER_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .elems_i(elems), .sums_o(sums_r));
  prefix_sum_scan #(.N(N), .W(W), .REGISTER_OUT(1'b0)) dut_c (
    .clk(clk), .rst(rst), .elems_i(elems), .sums_o(sums_c));

  function automatic logic [N*SW-1:0] ref_sums(input logic [N*W-1:0] v);
    logic [N*SW-1:0] r;
    logic [SW-1:0] acc;
    acc = '0;
    r   = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + SW'(v[i*W +: W]);
      r[i*SW +: SW] = acc;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [N*SW-1:0] act, input logic [N*SW-1:0] exp);
    for (int i = 0; i < N; i++) chk(req, act[i*SW +: SW], exp[i*SW +: SW]);
  endtask

  // Drives v; checks the combinational instance in the same cycle (R9)
  // and the registered one after the next edge (R7).
  task automatic apply(input string req, input logic [N*W-1:0] v);
    logic [N*SW-1:0] e;
    e = ref_sums(v);
    @(negedge clk);
    elems = v;
    #1;
    chk_all({req, "/R9"}, sums_c, e);
    @(posedge clk);
    #1;
    chk_all({req, "/R7"}, sums_r, e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    elems = {N{8'hA5}};
    @(posedge clk);
    #1;
    chk_all("R8", sums_r, '0);
    @(posedge clk);
    #1;
    chk_all("R8", sums_r, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_ramp;
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
    apply("R4", v);
    chk("R4", sums_r[0*SW +: SW], 1);
    chk("R4", sums_r[5*SW +: SW], 21);
    chk("R4", sums_r[6*SW +: SW], 28);
    chk("R3", sums_r[7*SW +: SW], 36);
    chk("R1", sums_c[SW-1:0], 1);
  endtask

  task automatic t_zero;
    apply("R2", '0);
  endtask

  task automatic t_max;
    apply("R5", '1);
    for (int i = 0; i < N; i++)
      chk("R5", sums_r[i*SW +: SW], SW'((i + 1) * ((1 << W) - 1)));
  endtask

  task automatic t_onehot;
    for (int p = 0; p < N; p++) begin
      logic [N*W-1:0] v;
      v = '0;
      v[p*W +: W] = W'(3 + p * 7);
      apply("R2", v);
      for (int i = 0; i < N; i++)
        chk("R2", sums_r[i*SW +: SW], (i >= p) ? SW'(3 + p * 7) : '0);
    end
  endtask

  task automatic t_alt;
    apply("R2", {N/2{8'hFF, 8'h01}});
    apply("R6", {N/2{8'h00, 8'h80}});
  endtask

  task automatic t_random;
    for (int n = 0; n < 40; n++) begin
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v[i*W +: W] = seed[W-1:0];
      end
      apply("R2", v);
      chk("R1", sums_r[SW-1:0], SW'(v[W-1:0]));
      for (int i = 1; i < N; i++) begin
        checks++;
        if (sums_r[i*SW +: SW] < sums_r[(i-1)*SW +: SW]) begin
          fails++;
          $display("FAIL R6 actual=%0d expected>=%0d",
                   sums_r[i*SW +: SW], sums_r[(i-1)*SW +: SW]);
        end
      end
    end
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_zero();
    t_max();
    t_onehot();
    t_alt();
    t_random();
    t_reset();
    t_ramp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule